// File: doc/BRIEF.md
# Synchronous Serial Shift Transceiver

This block is a full-duplex synchronous serial shift engine. A word written into the transmit port is sent one bit per bit period on the serial data output. In the same bit periods a word is collected from the serial data input. When the configured number of bits has been exchanged, the collected word is placed in the receive register and a single-cycle interrupt pulse is raised. Sending and collecting always happen together; the bits on the input are captured whether or not they carry anything useful.

The block runs either as clock master or as clock slave. As master, it generates the serial clock from an internal reload counter that ticks once per half bit period. As slave, it follows an external serial clock, which is resynchronised into the system clock domain and edge-detected. Configuration inputs select:

- the clock idle level,
- the clock phase: sample on the leading edge or on the trailing edge,
- the bit order: most or least significant bit first,
- the word length, from 2 to 16 bits.

The control state machine has four states:

- IDLE: nothing in progress.
- ARMED: master only; a word has been loaded and the engine waits for the first baud tick.
- SLV_WAIT: slave only; a word has been loaded and the first bit is already on the output.
- RUN: bits are being exchanged; the busy flag is high only here.

Transitions:

- load_master: IDLE to ARMED, on an accepted write in master mode.
- load_slave: IDLE to SLV_WAIT, on an accepted write in slave mode.
- first_tick: ARMED to RUN.
- first_edge: SLV_WAIT to RUN.
- last_edge: RUN to IDLE, once edge number 2N has been processed. This edge loads the receive register.
- abort: ARMED, SLV_WAIT or RUN to IDLE, whenever the enable input is low.

Top module: `sst_core`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are all low: `sdo`, `busy`, `rx_irq`, `sclk_out` and `rx_data`.
- R2: When `en`=1 and `master`=1 and no bit exchange is running, `sclk_out` equals `cpol`. When `en`=0 or `master`=0, `sclk_out` is 0.
- R3: Master start timing.
  - A `tx_wr` pulse sampled on clock edge P0, with `en`=1, `master`=1 and the engine idle, loads the word.
  - `sdo` then shows the first bit, and `busy` rises, at edge P0+`baud_reload`+1.
  - `sdo` and `busy` are unchanged before that edge.
  - A write is ignored when `en`=0 or while `busy`=1.
- R4: Bit exchange rules.
  - The leading clock edge is the one leaving the `cpol` level.
  - With `cpha`=0, input bits are sampled on leading edges and the output changes on trailing edges.
  - With `cpha`=1, the output changes on leading edges and input bits are sampled on trailing edges.
  - `lsb_first`=1 sends bit 0 first; `lsb_first`=0 sends bit N-1 first.
- R5: A master transfer of N bits produces exactly 2N clock edges, each `baud_reload`+1 system cycles after the one before.
- R6: Transfer completion.
  - After the last edge, `rx_data` holds the N received bits, right-aligned with bit positions as in R4.
  - `rx_irq` is high for exactly one cycle.
  - `busy` is low in that same cycle.
- R7: `sdo` is 0 before the first transfer after reset. Once a transfer ends, `sdo` keeps the level of the last bit sent until the next load.
- R8: `wsel` holds N-1, so values 1..15 give N = 2..16. `wsel`=0 is treated as N=2. Bits of `rx_data` at position N and above read 0.
- R9: In slave mode, a write drives the first bit on `sdo` in the cycle after the write. `busy` stays 0 until the first edge of `sclk_in` has been detected.
- R10: In slave mode, the engine follows the edges of `sclk_in` under the same phase and order rules as R4. The `sclk_in` idle level is `cpol`, and edges are resynchronised through two flops. After 2N edges it loads `rx_data` and pulses `rx_irq`.
- R11: Dropping `en` during a transfer returns the engine to idle on the next edge, with `busy` low. No `rx_irq` is raised and `rx_data` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| master | input | 1 | 1 = clock master, 0 = clock slave |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| lsb_first | input | 1 | 1 = least significant bit first |
| wsel | input | 4 | Word length minus one |
| baud_reload | input | 16 | Half bit period minus one, in system cycles |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 16 | Transmit word |
| rx_data | output | 16 | Receive register |
| rx_irq | output | 1 | Receive-complete pulse |
| busy | output | 1 | Bit exchange in progress |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_in | input | 1 | External serial clock in slave mode |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |

## Verification
The hardest situation to reach is the slave window between loading a word and the first external clock edge. In that window the first bit must already be on the output while busy is still low. The bench gets there by acting as the remote master itself: it toggles `sclk_in` by hand with long half periods and checks `sdo` and `busy` before its first toggle. It then supplies its own receive word bit by bit. In master mode, the input is looped back from `sdo`, optionally inverted. The bench also rebuilds the sent word from `sdo` values captured on the sample edges of `sclk_out`, so that bit-order and phase faults show up even though the loopback alone is symmetric.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_SLV_WAIT = 2'd2,
        ST_RUN      = 2'd3
    } st_t;

endpackage

// File: rtl/sst_baud.sv
module sst_baud #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] reload,
    output logic          tick
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= reload;
        end else if (run) begin
            if (cnt == '0) begin
                cnt <= reload;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    assign tick = run && !restart && (cnt == '0);

endmodule

// File: rtl/sst_esync.sv
module sst_esync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_p
);

    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], din};
        end
    end

    assign edge_p = sh[STAGES] ^ sh[STAGES-1];

endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
    import sst_pkg::*;
#(
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          master,
    input  logic          cpha,
    input  logic          tx_wr,
    input  logic          tick,
    input  logic          sedge,
    input  logic [KW-1:0] nbm1,
    output logic          load,
    output logic          drv_en,
    output logic [KW-1:0] drv_k,
    output logic          smp_en,
    output logic [KW-1:0] smp_k,
    output logic          commit,
    output logic          busy,
    output logic          phase,
    output logic          baud_run,
    output logic          baud_restart
);

    localparam int EW = KW + 2;

    st_t           state, nstate;
    logic [EW-1:0] ecnt, ecnt_n, e_in, last_e;
    logic          ph, ph_n, ev;

    assign last_e = {1'b0, nbm1, 1'b0} + EW'(2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ecnt  <= '0;
            ph    <= 1'b0;
        end else begin
            state <= nstate;
            ecnt  <= ecnt_n;
            ph    <= ph_n;
        end
    end

    // transitions and control outputs
    always_comb begin
        nstate       = state;
        ecnt_n       = ecnt;
        ph_n         = ph;
        load         = 1'b0;
        drv_en       = 1'b0;
        drv_k        = '0;
        smp_en       = 1'b0;
        smp_k        = '0;
        commit       = 1'b0;
        ev           = 1'b0;
        e_in         = '0;
        unique case (state)
            ST_IDLE: begin
                ph_n = 1'b0;
                if (en && tx_wr) begin
                    load   = 1'b1;
                    ecnt_n = '0;
                    if (master) begin
                        nstate = ST_ARMED;
                    end else begin
                        drv_en = 1'b1;
                        nstate = ST_SLV_WAIT;
                    end
                end
            end
            ST_ARMED: begin
                if (!en) begin
                    nstate = ST_IDLE;
                end else if (tick) begin
                    drv_en = 1'b1;
                    nstate = ST_RUN;
                    if (cpha) begin
                        ev   = 1'b1;
                        e_in = EW'(1);
                    end
                end
            end
            ST_SLV_WAIT: begin
                if (!en) begin
                    nstate = ST_IDLE;
                end else if (sedge) begin
                    ev     = 1'b1;
                    e_in   = EW'(1);
                    nstate = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    nstate = ST_IDLE;
                    ph_n   = 1'b0;
                end else if (master ? tick : sedge) begin
                    ev   = 1'b1;
                    e_in = ecnt + EW'(1);
                end
            end
        endcase

        if (ev) begin
            ecnt_n = e_in;
            ph_n   = ~ph;
            if (e_in[0]) begin
                if (cpha) begin
                    drv_en = 1'b1;
                    drv_k  = e_in[KW:1];
                end else begin
                    smp_en = 1'b1;
                    smp_k  = e_in[KW:1];
                end
            end else begin
                if (cpha) begin
                    smp_en = 1'b1;
                    smp_k  = e_in[KW:1] - KW'(1);
                end else if (e_in != last_e) begin
                    drv_en = 1'b1;
                    drv_k  = e_in[KW:1];
                end
            end
            if (e_in == last_e) begin
                commit = 1'b1;
                nstate = ST_IDLE;
            end
        end
    end

    assign busy         = (state == ST_RUN);
    assign phase        = ph && (state == ST_RUN);
    assign baud_run     = master && ((state == ST_ARMED) || (state == ST_RUN));
    assign baud_restart = load && master;

endmodule

// File: rtl/sst_dpath.sv
module sst_dpath #(
    parameter int DW = 16,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] tx_data,
    input  logic          drv_en,
    input  logic [KW-1:0] drv_k,
    input  logic          smp_en,
    input  logic [KW-1:0] smp_k,
    input  logic          commit,
    input  logic          lsb_first,
    input  logic [KW-1:0] nbm1,
    input  logic          sdi,
    output logic          sdo,
    output logic [DW-1:0] rx_data,
    output logic          rx_irq
);

    logic [DW-1:0] tx_buf, rx_sh, rx_next, src;
    logic [KW-1:0] dpos, spos;

    assign dpos = lsb_first ? drv_k : (nbm1 - drv_k);
    assign spos = lsb_first ? smp_k : (nbm1 - smp_k);
    assign src  = load ? tx_data : tx_buf;

    always_comb begin
        rx_next = rx_sh;
        if (smp_en) begin
            rx_next[spos] = sdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            rx_sh   <= '0;
            rx_data <= '0;
            sdo     <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            rx_irq <= commit;
            if (load) begin
                tx_buf <= tx_data;
                rx_sh  <= '0;
            end else begin
                rx_sh <= rx_next;
            end
            if (drv_en) begin
                sdo <= src[dpos];
            end
            if (commit) begin
                rx_data <= rx_next;
            end
        end
    end

endmodule

// File: rtl/sst_core.sv
module sst_core #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int SYNC = 2,
    localparam int KW  = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          master,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic [KW-1:0] wsel,
    input  logic [CW-1:0] baud_reload,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic [DW-1:0] rx_data,
    output logic          rx_irq,
    output logic          busy,
    output logic          sclk_out,
    input  logic          sclk_in,
    output logic          sdo,
    input  logic          sdi
);

    logic [KW-1:0] nbm1, drv_k, smp_k;
    logic          tick, sedge, load, drv_en, smp_en, commit, phase;
    logic          baud_run, baud_restart;

    assign nbm1 = (wsel == '0) ? KW'(1) : wsel;

    sst_baud #(.CW(CW)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (baud_restart),
        .run     (baud_run),
        .reload  (baud_reload),
        .tick    (tick)
    );

    sst_esync #(.STAGES(SYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (sclk_in),
        .edge_p (sedge)
    );

    sst_ctrl #(.KW(KW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .master       (master),
        .cpha         (cpha),
        .tx_wr        (tx_wr),
        .tick         (tick),
        .sedge        (sedge),
        .nbm1         (nbm1),
        .load         (load),
        .drv_en       (drv_en),
        .drv_k        (drv_k),
        .smp_en       (smp_en),
        .smp_k        (smp_k),
        .commit       (commit),
        .busy         (busy),
        .phase        (phase),
        .baud_run     (baud_run),
        .baud_restart (baud_restart)
    );

    sst_dpath #(.DW(DW), .KW(KW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tx_data   (tx_data),
        .drv_en    (drv_en),
        .drv_k     (drv_k),
        .smp_en    (smp_en),
        .smp_k     (smp_k),
        .commit    (commit),
        .lsb_first (lsb_first),
        .nbm1      (nbm1),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_data   (rx_data),
        .rx_irq    (rx_irq)
    );

    assign sclk_out = (en && master) ? (cpol ^ phase) : 1'b0;

endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
    parameter int DW = 16,
    parameter int KW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          master,
    input logic          cpol,
    input logic          tx_wr,
    input logic          busy,
    input logic          rx_irq,
    input logic          sdo,
    input logic          sclk_out,
    input logic [KW-1:0] nbm1,
    input logic [DW-1:0] rx_data
);

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R6

    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> !busy); // R6

    AST_RX_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ((32'(rx_data) >> (32'(nbm1) + 1)) == 0)); // R8

    AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !busy) |-> (sclk_out == cpol)); // R2

    AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !master) |-> !sclk_out); // R2

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_wr) |=> ($stable(sdo) || busy)); // R7

    AST_SLV_NO_EARLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && en && tx_wr && !busy) |=> !busy); // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy); // R11

endmodule

bind sst_core sst_chk #(.DW(DW), .KW(KW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .master   (master),
    .cpol     (cpol),
    .tx_wr    (tx_wr),
    .busy     (busy),
    .rx_irq   (rx_irq),
    .sdo      (sdo),
    .sclk_out (sclk_out),
    .nbm1     (nbm1),
    .rx_data  (rx_data)
);

// File: tb/sst_core_tb.sv
`timescale 1ns/1ps
module sst_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, master = 1'b1, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [3:0]  wsel = 4'd7;
    logic [15:0] baud_reload = 16'd1;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic [15:0] rx_data;
    logic        rx_irq, busy, sclk_out, sdo;
    logic        sclk_in = 1'b0;
    logic        sdi_s = 1'b0;
    logic        inv = 1'b0;
    logic        sdi;

    int nchk = 0, nfail = 0, done = 0;
    int edges = 0, gap_err = 0, capn = 0, irq_cnt = 0, gap_exp = 2, cyc = 0, last_cyc = 0;
    logic cap [32];
    logic prev_sc = 1'b0;

    always #10 clk = ~clk;

    assign sdi = master ? (inv ? ~sdo : sdo) : sdi_s;

    sst_core u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .wsel(wsel), .baud_reload(baud_reload), .tx_wr(tx_wr),
        .tx_data(tx_data), .rx_data(rx_data), .rx_irq(rx_irq), .busy(busy),
        .sclk_out(sclk_out), .sclk_in(sclk_in), .sdo(sdo), .sdi(sdi)
    );

    // bit-level monitor, sampling 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (sclk_out != prev_sc && master) begin
            edges = edges + 1;
            if (edges > 1 && (cyc - last_cyc) != gap_exp) gap_err = gap_err + 1;
            last_cyc = cyc;
            if (((sclk_out != cpol) ^ cpha) && capn < 32) begin
                cap[capn] = sdo;
                capn = capn + 1;
            end
        end
        prev_sc = sclk_out;
        if (rx_irq) irq_cnt = irq_cnt + 1;
        cyc = cyc + 1;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int posof(input int k, input int n, input logic lsb);
        return lsb ? k : n - 1 - k;
    endfunction

    // {cpol, cpha, lsb_first, inv, wsel[3:0], reload[7:0], tx[15:0]}
    localparam logic [31:0] VEC [9] = '{
        32'h0701_00A5, 32'h5700_003C, 32'hAF02_BEEF, 32'hFF01_1234, 32'h3103_FFFE,
        32'hCB00_0F5A, 32'h6402_FFE9, 32'h9901_0321, 32'h0001_0001
    };

    task automatic run_vec(input logic [31:0] v, input logic midwr);
        int n, rl, g;
        logic [15:0] mask, txm, exp_rx, word;
        logic prev, first, lastb;
        n    = (v[27:24] == 4'd0) ? 2 : int'(v[27:24]) + 1;
        rl   = int'(v[23:16]);
        mask = 16'((32'd1 << n) - 1);
        txm  = v[15:0] & mask;
        exp_rx = v[28] ? (~v[15:0] & mask) : txm;
        @(negedge clk);
        cpol = v[31]; cpha = v[30]; lsb_first = v[29]; inv = v[28];
        wsel = v[27:24]; baud_reload = 16'(rl); master = 1'b1; en = 1'b1;
        gap_exp = rl + 1;
        @(negedge clk);
        @(negedge clk);
        chk(sclk_out == cpol, "R2 idle clock level", 32'(sclk_out), 32'(cpol));
        edges = 0; gap_err = 0; capn = 0;
        prev = sdo;
        tx_data = v[15:0]; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (rl) @(negedge clk);
        chk(!busy && sdo == prev, "R3 no start before tick", {30'd0, busy, sdo}, {31'd0, prev});
        @(negedge clk);
        first = lsb_first ? v[0] : v[n-1];
        chk(busy && sdo == first, "R3 first bit at tick", {30'd0, busy, sdo}, {30'd0, 1'b1, first});
        if (midwr) begin
            tx_data = ~v[15:0]; tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
        end
        g = 0;
        while (!rx_irq && g < 5000) begin
            @(negedge clk);
            g++;
        end
        chk(rx_irq && !busy, "R6 irq with busy low", {30'd0, rx_irq, busy}, 32'h2);
        chk(rx_data == exp_rx, midwr ? "R3 write while busy ignored" : "R6 receive word",
            32'(rx_data), 32'(exp_rx));
        @(negedge clk);
        chk(!rx_irq, "R6 irq single cycle", 32'(rx_irq), 32'd0);
        chk(edges == 2 * n, n == 2 ? "R8 two-bit edge count" : "R5 edge count", edges, 2 * n);
        chk(gap_err == 0, "R5 edge spacing", gap_err, 0);
        word = '0;
        for (int k = 0; k < 16; k++) begin
            if (k < n && k < capn) word[posof(k, n, lsb_first)] = cap[k];
        end
        chk(word == txm, "R4 serial order and phase", 32'(word), 32'(txm));
        lastb = lsb_first ? v[n-1] : v[0];
        chk(sdo == lastb, "R7 sdo holds last bit", 32'(sdo), 32'(lastb));
        chk(sclk_out == cpol, "R2 clock back to idle", 32'(sclk_out), 32'(cpol));
    endtask

    task automatic slv_run(input logic pol, input logic ph, input logic lsb,
                           input logic [15:0] txw, input logic [15:0] rxw);
        int n, irq0;
        logic [15:0] word;
        logic first;
        n = 8;
        @(negedge clk);
        en = 1'b1; master = 1'b0; cpol = pol; cpha = ph; lsb_first = lsb; wsel = 4'd7;
        sclk_in = pol;
        repeat (6) @(negedge clk);
        chk(sclk_out == 1'b0, "R2 slave clock quiet", 32'(sclk_out), 32'd0);
        irq0 = irq_cnt;
        tx_data = txw; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        first = lsb ? txw[0] : txw[n-1];
        chk(sdo == first, "R9 slave first bit at load", 32'(sdo), 32'(first));
        repeat (6) @(negedge clk);
        chk(!busy, "R9 slave busy low before edge", 32'(busy), 32'd0);
        word = '0;
        for (int k = 0; k < n; k++) begin
            if (!ph) sdi_s = rxw[posof(k, n, lsb)];
            repeat (8) @(negedge clk);
            if (!ph) word[posof(k, n, lsb)] = sdo;
            sclk_in = ~pol;
            if (ph) sdi_s = rxw[posof(k, n, lsb)];
            repeat (6) @(negedge clk);
            if (k == 0) chk(busy, "R9 slave busy after first edge", 32'(busy), 32'd1);
            repeat (2) @(negedge clk);
            if (ph) word[posof(k, n, lsb)] = sdo;
            sclk_in = pol;
        end
        repeat (10) @(negedge clk);
        chk(rx_data == (rxw & 16'h00FF), "R10 slave receive word", 32'(rx_data), 32'(rxw & 16'h00FF));
        chk(irq_cnt == irq0 + 1, "R10 slave irq", irq_cnt, irq0 + 1);
        chk(word == (txw & 16'h00FF), "R10 slave serial output", 32'(word), 32'(txw & 16'h00FF));
        chk(!busy, "R10 slave idle after transfer", 32'(busy), 32'd0);
    endtask

    initial begin
        logic [15:0] rx_prev;
        int irq0;
        logic sdo_prev;
        repeat (3) @(negedge clk);
        chk({rx_data, rx_irq, busy, sdo, sclk_out} == 20'd0, "R1 reset state",
            32'({rx_data, rx_irq, busy, sdo, sclk_out}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rx_data, rx_irq, busy, sdo, sclk_out} == 20'd0, "R1 after reset release",
            32'({rx_data, rx_irq, busy, sdo, sclk_out}), 32'd0);
        cpol = 1'b1;
        @(negedge clk);
        chk(sclk_out == 1'b0, "R2 disabled clock low", 32'(sclk_out), 32'd0);
        // write while disabled is ignored
        irq0 = irq_cnt;
        tx_data = 16'hFFFF; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk(!busy && sdo == 1'b0 && irq_cnt == irq0, "R3 write ignored when disabled",
            {30'd0, busy, sdo}, 32'd0);
        en = 1'b1;
        @(negedge clk);
        chk(sclk_out == 1'b1, "R2 enabled idle level", 32'(sclk_out), 32'd1);
        chk(sdo == 1'b0, "R7 sdo low before first transfer", 32'(sdo), 32'd0);

        for (int i = 0; i < 9; i++) run_vec(VEC[i], 1'b0);
        run_vec(32'h0701_00A5, 1'b1);

        // abort by dropping enable
        @(negedge clk);
        rx_prev = rx_data;
        irq0 = irq_cnt;
        cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; wsel = 4'd7; baud_reload = 16'd3; inv = 1'b0;
        tx_data = 16'h0033; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy, "R11 transfer running before abort", 32'(busy), 32'd1);
        en = 1'b0;
        @(negedge clk);
        chk(!busy, "R11 busy drops on abort", 32'(busy), 32'd0);
        sdo_prev = sdo;
        repeat (80) @(negedge clk);
        chk(rx_data == rx_prev && irq_cnt == irq0, "R11 no receive after abort",
            32'(rx_data), 32'(rx_prev));
        chk(sdo == sdo_prev, "R7 sdo held while idle", 32'(sdo), 32'(sdo_prev));

        slv_run(1'b0, 1'b0, 1'b0, 16'h00C3, 16'h005A);
        slv_run(1'b1, 1'b1, 1'b1, 16'h0096, 16'h00E1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (done == 0) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule